// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block measures out programmable time intervals. The system clock is divided into a timer tick. A 6-bit reloading prescaler counts those ticks, and an 8-bit down-counter counts the prescaler's wrap events. When both counters finish together, the block raises a one-cycle interrupt request pulse. Software programs it through a plain write strobe with a 2-bit address. The live counter value is always visible on an output port, and reading that port has no side effects.

Two counting modes are available. In single-pass mode the timer stops at zero after one interval. In continuous mode the down-counter reloads and the next interval follows without a gap. Initial values written while the timer runs are held back. The prescaler picks up a new ratio when it next wraps, and the down-counter picks up a new initial value when it next reloads. Clearing the enable bit freezes all counting state. Setting it again resumes from the frozen state, except when the timer has come to rest after a single pass, in which case both initial values are loaded first.

Top module: `ivl_timer`

## Requirements
- R1: After reset, countOut is 0 and irqPulse is 0, and no pulse appears until the enable bit is written.
- R2: A write to address 0 sets the prescaler ratio from wrData[7:2] and the mode from wrData[0] (0 is single-pass, 1 is continuous). A write to address 1 sets the counter initial value. A write to address 2 sets the enable bit from wrData[0]. A write to address 3 has no effect.
- R3: One timer tick lasts TICK_DIV (4) clock cycles. The prescaler divides ticks by its ratio (1 to 63, and a field of 0 means 64). The pulse therefore comes 4 × ratio × value cycles after the enabling write.
- R4: A counter initial value of 0 counts 256 prescaler wraps.
- R5: irqPulse is high for exactly one clock cycle per interval.
- R6: In single-pass mode, after the pulse the counter rests at 0, the enable bit clears and no further pulse occurs. A later enable write reloads both initial values and times a full interval.
- R7: In continuous mode, the counter reloads its initial value in the cycle it finishes, and pulses repeat every 4 × ratio × value cycles.
- R8: Clearing the enable bit freezes countOut and suppresses pulses. Setting it again resumes without reload, so the total enabled time to the pulse is unchanged.
- R9: A counter initial value written during a run leaves countOut unchanged and takes effect at the next reload. A new prescaler ratio takes effect at the prescaler's next wrap.
- R10: countOut decreases by one each time the prescaler wraps, that is, every 4 × ratio cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address (0 prescaler/mode, 1 counter initial, 2 enable) |
| wrData | input | 8 | Write data |
| countOut | output | 8 | Live down-counter value |
| irqPulse | output | 1 | One-cycle end-of-interval request |

## Verification
Two situations are hard to reach from the ports: a new initial value arriving in the middle of a continuous run, and a pause in the middle of an interval. The bench writes the new value just after a pulse and times the next two intervals. It shows that the old counter value governs the first of them. It also shows that a new prescaler ratio changes that interval only after one full old-ratio prescaler cycle. For the pause, the bench disables the timer after a known number of cycles and holds it frozen for tens of cycles. It then checks that the remaining time to the pulse is exactly the balance of the programmed interval. The interval length is swept over all prescaler ratios and counter values from 1 to 4, plus the wrap encodings for 64 and 256.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;

  localparam logic [1:0] ADDR_PRE = 2'd0;
  localparam logic [1:0] ADDR_CNT = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic wrPre;      // capture prescaler ratio
    logic wrCnt;      // capture counter initial value
    logic load;       // copy both initial values into the counters
    logic step;       // timer tick while enabled
    logic keepGoing;  // continuous mode: reload at end of interval
  } tmrStrobe_t;

endpackage

// File: rtl/ivl_timer_ctrl.sv
module ivl_timer_ctrl
  import ivl_timer_pkg::*;
#(
  parameter int TICK_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic       wrBit0,
  input  logic       preAtEnd,
  input  logic       cntAtEnd,
  output tmrStrobe_t stb,
  output logic       irqPulse
);

  localparam int TD_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [TD_W-1:0] TD_LAST = TD_W'(TICK_DIV - 1);

  logic            enable;
  logic            needLoad;
  logic            contMode;
  logic [TD_W-1:0] tickDiv;
  logic            wrCtl;
  logic            intervalEnd;
  logic            singleDone;

  assign wrCtl         = wrEn && (wrAddr == ADDR_CTL);
  assign stb.wrPre     = wrEn && (wrAddr == ADDR_PRE);
  assign stb.wrCnt     = wrEn && (wrAddr == ADDR_CNT);
  assign stb.step      = enable && (tickDiv == TD_LAST);
  assign stb.load      = wrCtl && wrBit0 && !enable && needLoad;
  assign stb.keepGoing = contMode;

  assign intervalEnd = stb.step && preAtEnd && cntAtEnd;
  assign singleDone  = intervalEnd && !contMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickDiv <= '0;
    end else if (stb.load) begin
      tickDiv <= '0;
    end else if (enable) begin
      tickDiv <= (tickDiv == TD_LAST) ? '0 : tickDiv + TD_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable   <= 1'b0;
      needLoad <= 1'b1;
      contMode <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      irqPulse <= intervalEnd;
      if (stb.wrPre) contMode <= wrBit0;
      if (singleDone)  enable <= 1'b0;
      else if (wrCtl)  enable <= wrBit0;
      if (singleDone)    needLoad <= 1'b1;
      else if (stb.load) needLoad <= 1'b0;
    end
  end

  // R5: the request is a single-cycle pulse
  p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  // R6: a single-pass end leaves the timer disabled
  p_single_halt_r6: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse && !$past(contMode)) |-> !enable);

  // R6: starting from rest arms the timer and consumes the load request
  p_load_arms_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (enable && !needLoad));

  // R3: ticks are spaced by more than one cycle
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |=> !stb.step);

endmodule

// File: rtl/ivl_timer_dp.sv
module ivl_timer_dp
  import ivl_timer_pkg::*;
#(
  parameter int PRE_W = 6,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       stb,
  input  logic [CNT_W-1:0] wrData,
  output logic             preAtEnd,
  output logic             cntAtEnd,
  output logic [CNT_W-1:0] countOut
);

  localparam int PRE_LSB = CNT_W - PRE_W;

  logic [PRE_W-1:0] preInit;
  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] cntInit;
  logic [CNT_W-1:0] cnt;

  // a value of 1 is the last count; 0 stands for the full 2^W range
  assign preAtEnd = (preCnt == PRE_W'(1));
  assign cntAtEnd = (cnt == CNT_W'(1));
  assign countOut = cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preInit <= '0;
      cntInit <= '0;
    end else begin
      if (stb.wrPre) preInit <= wrData[CNT_W-1:PRE_LSB];
      if (stb.wrCnt) cntInit <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (stb.load) begin
      preCnt <= preInit;
    end else if (stb.step) begin
      preCnt <= preAtEnd ? preInit : preCnt - PRE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (stb.load) begin
      cnt <= cntInit;
    end else if (stb.step && preAtEnd) begin
      if (cntAtEnd) cnt <= stb.keepGoing ? cntInit : '0;
      else          cnt <= cnt - CNT_W'(1);
    end
  end

  // R8: without a tick or load the count holds
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.step && !stb.load) |=> $stable(cnt));

  // R10: a prescaler wrap mid-interval decrements by exactly one
  p_decrement_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && preAtEnd && !cntAtEnd && !stb.load)
      |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R3: the prescaler restarts from its held ratio at its wrap
  p_pre_reload_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && preAtEnd && !stb.load) |=> (preCnt == $past(preInit)));

  // R6: single-pass rests at zero
  p_rest_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && preAtEnd && cntAtEnd && !stb.keepGoing) |=> (cnt == '0));

  // R7 R9: continuous end reloads the held initial value
  p_cont_reload_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && preAtEnd && cntAtEnd && stb.keepGoing) |=> (cnt == $past(cntInit)));

endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
  import ivl_timer_pkg::*;
#(
  parameter int TICK_DIV = 4,
  parameter int PRE_W    = 6,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] countOut,
  output logic             irqPulse
);

  tmrStrobe_t stb;
  logic       preAtEnd;
  logic       cntAtEnd;

  ivl_timer_ctrl #(.TICK_DIV(TICK_DIV)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrBit0   (wrData[0]),
    .preAtEnd (preAtEnd),
    .cntAtEnd (cntAtEnd),
    .stb      (stb),
    .irqPulse (irqPulse)
  );

  ivl_timer_dp #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (wrData),
    .preAtEnd (preAtEnd),
    .cntAtEnd (cntAtEnd),
    .countOut (countOut)
  );

endmodule

// File: tb/ivl_timer_bench.sv
module ivl_timer_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] countOut;
  logic       irqPulse;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  ivl_timer u_ivl_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .countOut(countOut), .irqPulse(irqPulse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge; the write is taken at the next posedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitIrq(output int n, input int limit);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irqPulse && n < limit);
  endtask

  task automatic idle(input int len, output int seen);
    seen = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (irqPulse) seen++;
    end
  endtask

  task automatic oneShot(input int p, input int v);
    int n, seen;
    logic [5:0] pf;
    logic [7:0] vf;
    pf = 6'(p % 64);
    vf = 8'(v % 256);
    wr(2'd0, {pf, 2'b00});
    wr(2'd1, vf);
    wr(2'd2, 8'h01);
    waitIrq(n, 70000);
    chk($sformatf("R3 R4 R6 interval p=%0d v=%0d", p, v), n, 4 * p * v);
    @(negedge clk);
    chk("R5 pulse width", int'(irqPulse), 0);
    chk("R6 rest value", int'(countOut), 0);
    idle(10, seen);
    chk("R6 no pulse after single pass", seen, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        nFails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
        $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    int n, seen, bad, frozen;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1 count after reset", int'(countOut), 0);
    chk("R1 irq after reset", int'(irqPulse), 0);
    idle(20, seen);
    chk("R1 no pulse while idle", seen, 0);

    // R2 address 3 ignored
    wr(2'd3, 8'hFF);
    idle(40, seen);
    chk("R2 address 3 no start", seen, 0);
    chk("R2 address 3 count", int'(countOut), 0);

    // R3 R4 R6 sweep of small ratios and values
    for (int p = 1; p <= 4; p++)
      for (int v = 1; v <= 4; v++)
        oneShot(p, v);
    oneShot(64, 2);
    oneShot(1, 256);

    // R10 live count, ratio 2, value 5
    wr(2'd0, {6'd2, 2'b00});
    wr(2'd1, 8'd5);
    wr(2'd2, 8'h01);
    bad = 0;
    for (int k = 1; k < 40; k++) begin
      @(negedge clk);
      if (int'(countOut) != 5 - k / 8) bad++;
    end
    chk("R10 live count mismatches", bad, 0);
    waitIrq(n, 100);
    chk("R10 final pulse", n, 1);

    // R7 continuous, ratio 3, value 2
    wr(2'd0, {6'd3, 2'b01});
    wr(2'd1, 8'd2);
    wr(2'd2, 8'h01);
    waitIrq(n, 1000);
    chk("R7 first interval", n, 24);
    chk("R7 reload value", int'(countOut), 2);
    // R9 deferred counter value
    wr(2'd1, 8'd4);
    chk("R9 count not disturbed", int'(countOut), 2);
    waitIrq(n, 1000);
    chk("R9 old value governs interval", n + 1, 24);
    chk("R9 new value at reload", int'(countOut), 4);
    // R9 deferred prescaler ratio: one old cycle of 3, then ratio 1
    wr(2'd0, {6'd1, 2'b01});
    waitIrq(n, 1000);
    chk("R9 ratio change at wrap", n + 1, 24);
    waitIrq(n, 1000);
    chk("R7 repeat with new settings", n, 16);

    // leave continuous mode and let the run settle to rest
    wr(2'd2, 8'h00);
    wr(2'd0, {6'd2, 2'b00});
    wr(2'd2, 8'h01);
    waitIrq(n, 5000);

    // R8 freeze and resume, ratio 2, value 3
    wr(2'd1, 8'd3);
    wr(2'd2, 8'h01);
    repeat (10) @(negedge clk);
    wr(2'd2, 8'h00);
    chk("R8 frozen value", int'(countOut), 2);
    frozen = int'(countOut);
    idle(30, seen);
    chk("R8 value held", int'(countOut), frozen);
    chk("R8 no pulse while frozen", seen, 0);
    wr(2'd2, 8'h01);
    waitIrq(n, 1000);
    chk("R8 remaining time", n, 13);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule